// File: doc/BRIEF.md
# Grouped Error Interrupt Controller

This block collects single-cycle error event pulses and eight level-sensitive device interrupt lines into one 32-bit status word, with a matching 32-bit enable word of identical layout. Error bits are sticky. Software removes them by writing group-select bits to a write-only clear register. Each select bit wipes a fixed set of related status bits, so one write clears a whole family of errors.

A second error on a cause that is already pending sets a multi-error flag. A level interrupt output is raised whenever an enabled status bit is set. A separate fatal output follows a fixed subset of error bits, whatever the enables hold. An eight-entry routing table assigns a device number to each device line. The block reports the device number of the lowest-indexed pending, enabled device line.

Access is through a simple register port. Writes take effect on the clock edge. Read data is combinational on the address. Register addresses (reg_addr): 0 is status (read-only), 1 is enable (read/write), 2 is group clear (write-only, reads 0), and 3 is routing (read/write, 24 bits).

Top module: `grp_err_irq`

## Requirements
- R1: After reset, status, enable and routing all read 0, and irq_o, fatal_o and irq_dev_o are 0.
- R2: A pulse on err_evt_i[k] sets status bit k+8 at the next clock edge. The bit then stays set until a group clear covers it.
- R3: A pulse on err_evt_i[k] while status bit k+8 is already set sets status bit 31, the multi-error flag, at the next clock edge.
- R4: Writing 1 to a bit of the clear register (address 2) clears that bit's status group at the next edge. The groups are:
  - bit 0: bits 8 and 10 to 15
  - bit 1: bits 16 and 30
  - bit 2: bits 17 to 21
  - bit 3: bits 23, 24, 25 and 27
  - bit 4: bits 9, 26 and 28
  - bit 5: bits 22 and 29
  - bit 6: bit 31

  Writing 0x7F clears every error bit.
- R5: When an error pulse or a multi-error event hits a bit that is being cleared in the same cycle, the bit ends up set.
- R6: fatal_o is 1 exactly when any of status bits 13, 14 or 22 to 29 is set. Bit 9 and the enable register have no effect on it.
- R7: irq_o is 1 exactly when some bit of (status AND enable) is 1, with both words using the same bit positions.
- R8: Writes to the status address (address 0) leave the status register unchanged.
- R9: The routing register holds a 3-bit device number for line n at bits 3n+2 to 3n. irq_dev_o gives the number for the lowest n whose status bit n and enable bit n are both 1. It is 0 when no line qualifies.
- R10: Status bits 7 to 0 show dev_line_i as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| err_evt_i | input | 23 | Error event pulses; bit k targets status bit k+8 |
| dev_line_i | input | 8 | Device interrupt lines (level) |
| irq_o | output | 1 | Level interrupt request |
| fatal_o | output | 1 | Fatal error indication |
| irq_dev_o | output | 3 | Routed device number of the winning line |

## Verification
The bench builds the block with its default parameters: eight device lines and 3-bit device numbers. With these values the whole 32-bit layout is populated, so every one of the seven clear groups, the full fatal subset and all eight routing fields can be reached. Random pulses are kept sparse, so that repeat hits on pending bits and clears that collide with new events both occur often.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int DATA_W    = 32;
    localparam int ERR_LO    = 8;
    localparam int ERR_HI    = 30;
    localparam int ERR_W     = ERR_HI - ERR_LO + 1;
    localparam int MULTI_BIT = 31;
    localparam int NUM_GRP   = 7;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CLEAR  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_ROUTE  = 2'd3;

    // error bits that drive the fatal output: 13, 14, 22..29
    localparam logic [DATA_W-1:0] FATAL_MASK = 32'h3FC0_6000;

    function automatic logic [DATA_W-1:0] grp_mask(input int g);
        case (g)
            0:       return 32'h0000_FD00;
            1:       return 32'h4001_0000;
            2:       return 32'h003E_0000;
            3:       return 32'h0B80_0000;
            4:       return 32'h1400_0200;
            5:       return 32'h2040_0000;
            6:       return 32'h8000_0000;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/eic_status_core.sv
module eic_status_core
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ERR_W-1:0]     evt_i,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 clr_we_i,
    input  logic [NUM_GRP-1:0]   clr_sel_i,
    output logic [DATA_W-1:0]    status_o
);
    typedef struct packed {
        logic [DATA_W-1:0] status;
    } core_t;

    core_t st_d, st_q;
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] clr_mask;
    logic              multi_hit;

    always_comb begin
        evt_vec = '0;
        evt_vec[ERR_HI:ERR_LO] = evt_i;
        clr_mask = '0;
        if (clr_we_i) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (clr_sel_i[g]) clr_mask = clr_mask | grp_mask(g);
            end
        end
        multi_hit = |(evt_vec & st_q.status);
        st_d = st_q;
        st_d.status = (st_q.status & ~clr_mask) | evt_vec;
        st_d.status[MULTI_BIT] = (st_q.status[MULTI_BIT] & ~clr_mask[MULTI_BIT]) | multi_hit;
        st_d.status[NUM_LINES-1:0] = line_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R2 and R5: a pulsed cause is set after the edge, even under a clear
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_o[ERR_HI:ERR_LO] & $past(evt_i)) == $past(evt_i)));

    // R3: repeat hit raises the multi-error flag
    a_r3_multi: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & status_o[ERR_HI:ERR_LO]) != '0) |=> status_o[MULTI_BIT]);

    // R4: without a clear write, error bits never fall
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((status_o[DATA_W-1:ERR_LO] & $past(status_o[DATA_W-1:ERR_LO]))
                       == $past(status_o[DATA_W-1:ERR_LO])));
endmodule

// File: rtl/eic_route_table.sv
module eic_route_table #(
    parameter int NUM_LINES = 8,
    parameter int DEV_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [NUM_LINES*DEV_W-1:0] wdata_i,
    input  logic [NUM_LINES-1:0]       pend_i,
    output logic [NUM_LINES*DEV_W-1:0] route_o,
    output logic [DEV_W-1:0]           dev_o
);
    localparam int TBL_W = NUM_LINES * DEV_W;

    typedef struct packed {
        logic [TBL_W-1:0] tbl;
    } rt_t;

    rt_t rt_d, rt_q;
    logic [DEV_W-1:0] field [NUM_LINES];

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_field
            assign field[n] = rt_q.tbl[n*DEV_W +: DEV_W];
        end
    endgenerate

    always_comb begin
        rt_d = rt_q;
        if (we_i) rt_d.tbl = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    always_comb begin
        dev_o = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) dev_o = field[i];
        end
    end

    assign route_o = rt_q.tbl;

    // R9: line 0 pending always wins
    a_r9_prio0: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i[0] |-> (dev_o == route_o[DEV_W-1:0]));
    // R9: nothing pending gives device 0
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> (dev_o == '0));
endmodule

// File: rtl/grp_err_irq.sv
module grp_err_irq
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DEV_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [ERR_W-1:0]     err_evt_i,
    input  logic [NUM_LINES-1:0] dev_line_i,
    output logic                 irq_o,
    output logic                 fatal_o,
    output logic [DEV_W-1:0]     irq_dev_o
);
    localparam int TBL_W = NUM_LINES * DEV_W;

    typedef struct packed {
        logic [DATA_W-1:0] enable;
    } top_t;

    top_t tp_d, tp_q;
    logic [DATA_W-1:0] status;
    logic [TBL_W-1:0]  route;
    logic              clr_we, route_we;

    assign clr_we   = reg_we && (reg_addr == ADR_CLEAR);
    assign route_we = reg_we && (reg_addr == ADR_ROUTE);

    always_comb begin
        tp_d = tp_q;
        if (reg_we && (reg_addr == ADR_ENABLE)) tp_d.enable = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    eic_status_core #(.NUM_LINES(NUM_LINES)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (err_evt_i),
        .line_i    (dev_line_i),
        .clr_we_i  (clr_we),
        .clr_sel_i (reg_wdata[NUM_GRP-1:0]),
        .status_o  (status)
    );

    eic_route_table #(.NUM_LINES(NUM_LINES), .DEV_W(DEV_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (route_we),
        .wdata_i (reg_wdata[TBL_W-1:0]),
        .pend_i  (status[NUM_LINES-1:0] & tp_q.enable[NUM_LINES-1:0]),
        .route_o (route),
        .dev_o   (irq_dev_o)
    );

    assign irq_o   = |(status & tp_q.enable);
    assign fatal_o = |(status & FATAL_MASK);

    always_comb begin
        case (reg_addr)
            ADR_STATUS: reg_rdata = status;
            ADR_ENABLE: reg_rdata = tp_q.enable;
            ADR_ROUTE:  reg_rdata = {{(DATA_W-TBL_W){1'b0}}, route};
            default:    reg_rdata = '0;
        endcase
    end

    // R7: nothing enabled, no interrupt
    a_r7_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_q.enable == '0) |-> !irq_o);
    // R6: a pulse on a fatal cause raises fatal on the next cycle
    a_r6_fatal_evt: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_evt_i & FATAL_MASK[ERR_HI:ERR_LO]) != '0) |=> fatal_o);
endmodule

// File: tb/tb_grp_err_irq.sv
module tb_grp_err_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [22:0] err_evt_i = '0;
    logic [7:0]  dev_line_i = '0;
    logic        irq_o, fatal_o;
    logic [2:0]  irq_dev_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_st, m_en;
    logic [23:0] m_rt;

    always #5 clk = ~clk;

    grp_err_irq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt_i(err_evt_i),
        .dev_line_i(dev_line_i), .irq_o(irq_o), .fatal_o(fatal_o), .irq_dev_o(irq_dev_o)
    );

    function automatic logic [31:0] gmask(input logic [6:0] sel);
        logic [31:0] m = '0;
        if (sel[0]) m |= (32'h1 << 8) | (32'h3F << 10);
        if (sel[1]) m |= (32'h1 << 16) | (32'h1 << 30);
        if (sel[2]) m |= (32'h1F << 17);
        if (sel[3]) m |= (32'h1 << 23) | (32'h1 << 24) | (32'h1 << 25) | (32'h1 << 27);
        if (sel[4]) m |= (32'h1 << 9) | (32'h1 << 26) | (32'h1 << 28);
        if (sel[5]) m |= (32'h1 << 22) | (32'h1 << 29);
        if (sel[6]) m |= (32'h1 << 31);
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_st;
            2'd1: return m_en;
            2'd3: return {8'h00, m_rt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [2:0] exp_dev();
        logic [7:0] p = m_st[7:0] & m_en[7:0];
        for (int i = 0; i < 8; i++) if (p[i]) return m_rt[i*3 +: 3];
        return 3'd0;
    endfunction

    function automatic logic exp_fatal();
        logic [31:0] fm = (32'hFF << 22) | (32'h1 << 13) | (32'h1 << 14);
        return |(m_st & fm);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_edge(input logic we, input logic [1:0] a, input logic [31:0] wd,
                              input logic [22:0] ev, input logic [7:0] ln);
        logic [31:0] evv = {1'b0, ev, 8'h00};
        logic hit = |(evv & m_st);
        logic [31:0] cm = (we && a == 2'd2) ? gmask(wd[6:0]) : 32'h0;
        logic [31:0] ns = (m_st & ~cm) | evv;
        if (hit) ns[31] = 1'b1;
        ns[7:0] = ln;
        m_st = ns;
        if (we && a == 2'd1) m_en = wd;
        if (we && a == 2'd3) m_rt = wd[23:0];
    endtask

    task automatic check_outs(input string tag);
        chk("R7", {tag, " irq"}, {31'h0, irq_o}, {31'h0, |(m_st & m_en)});
        chk("R6", {tag, " fatal"}, {31'h0, fatal_o}, {31'h0, exp_fatal()});
        chk("R9", {tag, " dev"}, {29'h0, irq_dev_o}, {29'h0, exp_dev()});
    endtask

    // one cycle: drive at negedge, check read data, update model at posedge, check outputs
    task automatic step(input string tag, input logic we, input logic [1:0] a, input logic [31:0] wd,
                        input logic [22:0] ev, input logic [7:0] ln);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd; err_evt_i = ev; dev_line_i = ln;
        #1;
        if (!we) chk(tag, "rdata", reg_rdata, exp_rd(a));
        @(posedge clk);
        model_edge(we, a, wd, ev, ln);
        #1;
        check_outs(tag);
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        step(tag, 1'b0, a, 32'h0, 23'h0, dev_line_i);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_st = '0; m_en = '0; m_rt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check_outs("R1");
        rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd3); rd("R1", 2'd2);
        // R2 sticky set
        step("R2", 1'b0, 2'd0, 0, 23'h1 << 7, 8'h00);
        rd("R2", 2'd0); rd("R2", 2'd0);
        // R3 repeat hit
        step("R3", 1'b0, 2'd0, 0, 23'h1 << 7, 8'h00);
        rd("R3", 2'd0);
        // R4 each group alone, then all
        for (int g = 0; g < 7; g++) begin
            step("R4", 1'b0, 2'd0, 0, 23'h7FFFFF, 8'h00);
            step("R4", 1'b0, 2'd0, 0, 23'h7FFFFF, 8'h00);
            step("R4", 1'b1, 2'd2, 32'h1 << g, 23'h0, 8'h00);
            rd("R4", 2'd0);
        end
        step("R4", 1'b1, 2'd2, 32'h7F, 23'h0, 8'h00);
        rd("R4", 2'd0);
        // R5 set beats clear of same bit (bit 12 in group 0)
        step("R5", 1'b1, 2'd2, 32'h1, 23'h1 << 4, 8'h00);
        rd("R5", 2'd0);
        step("R5", 1'b1, 2'd2, 32'h7F, 23'h0, 8'h00);
        // R6 bit 9 alone is not fatal, bit 13 is
        step("R6", 1'b0, 2'd0, 0, 23'h1 << 1, 8'h00);
        rd("R6", 2'd0);
        step("R6", 1'b0, 2'd0, 0, 23'h1 << 5, 8'h00);
        rd("R6", 2'd0);
        // R7 enable gating
        step("R7", 1'b1, 2'd1, 32'h0000_0200, 23'h0, 8'h00);
        rd("R7", 2'd1);
        step("R7", 1'b1, 2'd1, 32'h0000_0100, 23'h0, 8'h00);
        rd("R7", 2'd0);
        // R8 status write ignored
        step("R8", 1'b1, 2'd0, 32'hFFFF_FFFF, 23'h0, 8'h00);
        rd("R8", 2'd0);
        step("R8", 1'b1, 2'd0, 32'h0, 23'h0, 8'h00);
        rd("R8", 2'd0);
        // R10 and R9: lines and routing
        step("R9", 1'b1, 2'd3, 32'h00FA_C688, 23'h0, 8'h00);
        rd("R9", 2'd3);
        step("R9", 1'b1, 2'd1, 32'h0000_00FF, 23'h0, 8'h00);
        step("R10", 1'b0, 2'd0, 0, 23'h0, 8'h90);
        rd("R10", 2'd0);
        step("R9", 1'b0, 2'd0, 0, 23'h0, 8'h08);
        step("R9", 1'b0, 2'd0, 0, 23'h0, 8'h01);
        step("R9", 1'b1, 2'd1, 32'h0000_00FE, 23'h0, 8'h81);
        rd("R9", 2'd0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic we = ($urandom % 3) == 0;
            logic [1:0] a = 2'($urandom % 4);
            logic [31:0] wd = $urandom;
            logic [22:0] ev = '0;
            logic [7:0] ln = dev_line_i;
            if (a == 2'd2 && ($urandom % 2) == 0) wd = 32'h1 << ($urandom % 7);
            if (($urandom % 3) == 0) ev = 23'h1 << ($urandom % 23);
            if (($urandom % 8) == 0) ev |= 23'h1 << ($urandom % 23);
            if (($urandom % 5) == 0) ln = 8'($urandom);
            step("R2", we, a, wd, ev, ln);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule